// File: doc/BRIEF.md
# Bus Traffic Statistics Collector

This block watches a shared processor bus and keeps per-window rates of coherence-related traffic. For every completed transaction the bus front end presents a decoded type code together with a strobe and a snoop-hit indication from the snoop phase. The collector sorts each transaction into four classes and counts each class. The classes are cache-to-cache transfers, zero-length read-invalidate requests (upgrade misses), full-line read-invalidate requests, and plain burst full-line reads.

A free-running window timer marks the end of each measurement interval, which is a fixed number of bus clock cycles (one second at the bus frequency by default). In that one cycle all four counters are copied into a snapshot and cleared. Each event therefore lands in exactly one window. The transfer count and the full-line read count always come from the same interval, so a host can divide one by the other to get a hit rate. The snapshot is then sent as a byte stream over a valid/ready handshake to a serial transmitter outside the block. Each frame is a sync byte followed by the four counters, least-significant byte first.

The sender is one state machine with three states. In IDLE it waits for a window end. The transition IDLE→SYNC loads the snapshot. In SYNC it offers the sync byte, and SYNC→DATA follows its acceptance. In DATA it offers the counter bytes in turn, and DATA→IDLE follows acceptance of the last one. If a window ends while the state is not IDLE, the new snapshot is dropped, the frame in flight continues, and a sticky overrun flag is raised.

Top module: `bus_stats_collector`

## Requirements
- R1: On a clock edge with `txn_valid` high, `txn_type` 0 (full-line read) adds one to the burst-read count, 1 (zero-length read-invalidate) adds one to the zero-invalidate count, and 2 (full-line read-invalidate) adds one to the line-invalidate count. Type 3 and any edge with `txn_valid` low count nothing, whatever `snoop_hit` is.
- R2: A transaction with `txn_valid` high, `snoop_hit` high and `txn_type` 0 or 2 also adds one to the cache-to-cache count.
- R3: Windows are `WINDOW_CYCLES` clock edges long, and the first one ends on edge `WINDOW_CYCLES` after reset is released. The snapshot includes an event sampled on the ending edge, and the counters restart from zero on the next edge.
- R4: A frame is the byte 0xA5 followed by the cache-to-cache, zero-invalidate, line-invalidate and burst-read counts, in that order. Each count is sent as `CNT_W/8` bytes, least-significant byte first.
- R5: A byte is consumed only on an edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` low, `tx_valid` and `tx_data` hold.
- R6: A counter that reaches 2^`CNT_W`−1 stays there for the rest of the window instead of wrapping.
- R7: If a window ends while a frame is still being sent, `overrun` goes high and stays high until reset. The frame in flight completes with its original contents, and the new snapshot is discarded.
- R8: After reset, `tx_valid` and `overrun` are low and all counts are zero.
- R9: No frame starts before the first window ends, and `tx_valid` is low between the last byte of a frame and the next window end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| txn_valid | input | 1 | Strobe: a completed transaction is presented this cycle |
| txn_type | input | 2 | Decoded transaction type (0 line read, 1 zero-length read-invalidate, 2 line read-invalidate, 3 other) |
| snoop_hit | input | 1 | Another agent returned a modified-line hit and supplies the data |
| tx_ready | input | 1 | Serial transmitter can accept a byte |
| tx_valid | output | 1 | A frame byte is offered on tx_data |
| tx_data | output | 8 | Frame byte |
| overrun | output | 1 | Sticky: a snapshot was dropped because the previous frame was still in flight |

## Verification
The inputs are driven by an arithmetic pattern that changes with the window number. It mixes all four type codes with and without the strobe and with snoop hits on every type. This separates a wrong class decode, a cache-to-cache count taken on the wrong types, and hits counted without a strobe. One window uses only type 3 and strobe-less hits, so any non-zero count shows that ignored traffic leaked into a counter. Back-pressure patterns and a long stall that spans a window end test byte holding, frame order, the dropped snapshot and the sticky overrun. A second instance with 8-bit counters and a long window gets a run of heavy traffic. This checks that saturated classes read 255 while unsaturated classes in the same window still read exactly.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [1:0] {
        TXN_LINE_READ = 2'd0,
        TXN_RFO_ZERO  = 2'd1,
        TXN_RFO_LINE  = 2'd2,
        TXN_OTHER     = 2'd3
    } txn_kind_e;

    localparam int NUM_CLASSES  = 4;
    localparam int CLS_C2C      = 0;
    localparam int CLS_INV_ZERO = 1;
    localparam int CLS_INV_LINE = 2;
    localparam int CLS_BURST    = 3;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SYNC = 2'd1,
        TX_DATA = 2'd2
    } tx_state_e;

endpackage

// File: rtl/bsc_classifier.sv
module bsc_classifier
    import bsc_pkg::*;
(
    input  logic                   txn_valid,
    input  logic [1:0]             txn_type,
    input  logic                   snoop_hit,
    output logic [NUM_CLASSES-1:0] inc
);

    txn_kind_e kind;

    always_comb begin
        kind = txn_kind_e'(txn_type);
        inc  = '0;
        if (txn_valid) begin
            unique case (kind)
                TXN_LINE_READ: begin
                    inc[CLS_BURST] = 1'b1;
                    inc[CLS_C2C]   = snoop_hit;
                end
                TXN_RFO_ZERO: begin
                    inc[CLS_INV_ZERO] = 1'b1;
                end
                TXN_RFO_LINE: begin
                    inc[CLS_INV_LINE] = 1'b1;
                    inc[CLS_C2C]      = snoop_hit;
                end
                TXN_OTHER: begin
                    inc = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bsc_window_timer.sv
module bsc_window_timer #(
    parameter int WINDOW_CYCLES = 66_666_667
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int TW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(WINDOW_CYCLES - 1);

    logic [TW-1:0] count_q;

    assign tick = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/bsc_sat_counters.sv
module bsc_sat_counters #(
    parameter int NUM   = 4,
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM-1:0]       inc,
    input  logic                 clear,
    output logic [NUM*CNT_W-1:0] cnt_flat,
    output logic [NUM*CNT_W-1:0] snap_flat
);

    localparam logic [CNT_W-1:0] MAX = '1;

    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic             bump;

        assign bump = inc[g] && (cnt_q != MAX);
        assign cnt_flat[g*CNT_W +: CNT_W]  = cnt_q;
        assign snap_flat[g*CNT_W +: CNT_W] = bump ? cnt_q + 1'b1 : cnt_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (clear) begin
                cnt_q <= '0;
            end else if (bump) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bsc_frame_sender.sv
module bsc_frame_sender
    import bsc_pkg::*;
#(
    parameter int          NUM       = 4,
    parameter int          CNT_W     = 32,
    parameter logic [7:0]  SYNC_BYTE = 8'hA5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM*CNT_W-1:0] load_data,
    input  logic                 tx_ready,
    output logic                 tx_valid,
    output logic [7:0]           tx_data,
    output logic                 overrun
);

    localparam int BYTES_PER   = CNT_W / 8;
    localparam int TOTAL_BYTES = NUM * BYTES_PER;
    localparam int IW          = (TOTAL_BYTES > 2) ? $clog2(TOTAL_BYTES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(TOTAL_BYTES - 1);

    tx_state_e            state_q, state_d;
    logic [NUM*CNT_W-1:0] frame_q;
    logic [IW-1:0]        idx_q;
    logic                 overrun_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load) state_d = TX_SYNC;
            TX_SYNC: if (tx_ready) state_d = TX_DATA;
            TX_DATA: if (tx_ready && idx_q == LAST_IDX) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    // frame shift register, byte index and overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q   <= '0;
            idx_q     <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (load && state_q != TX_IDLE) begin
                overrun_q <= 1'b1;
            end
            if (state_q == TX_IDLE && load) begin
                frame_q <= load_data;
                idx_q   <= '0;
            end else if (state_q == TX_DATA && tx_ready) begin
                frame_q <= frame_q >> 8;
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        unique case (state_q)
            TX_IDLE: begin
                tx_valid = 1'b0;
                tx_data  = 8'h00;
            end
            TX_SYNC: begin
                tx_valid = 1'b1;
                tx_data  = SYNC_BYTE;
            end
            TX_DATA: begin
                tx_valid = 1'b1;
                tx_data  = frame_q[7:0];
            end
            default: begin
                tx_valid = 1'b0;
                tx_data  = 8'h00;
            end
        endcase
    end

    assign overrun = overrun_q;

endmodule

// File: rtl/bus_stats_collector.sv
module bus_stats_collector
    import bsc_pkg::*;
#(
    parameter int         WINDOW_CYCLES = 66_666_667,
    parameter int         CNT_W         = 32,
    parameter logic [7:0] SYNC_BYTE     = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_valid,
    input  logic [1:0] txn_type,
    input  logic       snoop_hit,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       overrun
);

    logic [NUM_CLASSES-1:0]       class_inc;
    logic                         win_tick;
    logic [NUM_CLASSES*CNT_W-1:0] cnt_flat;
    logic [NUM_CLASSES*CNT_W-1:0] snap_flat;

    bsc_classifier u_class (
        .txn_valid (txn_valid),
        .txn_type  (txn_type),
        .snoop_hit (snoop_hit),
        .inc       (class_inc)
    );

    bsc_window_timer #(
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (win_tick)
    );

    bsc_sat_counters #(
        .NUM   (NUM_CLASSES),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (class_inc),
        .clear     (win_tick),
        .cnt_flat  (cnt_flat),
        .snap_flat (snap_flat)
    );

    bsc_frame_sender #(
        .NUM       (NUM_CLASSES),
        .CNT_W     (CNT_W),
        .SYNC_BYTE (SYNC_BYTE)
    ) u_send (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (win_tick),
        .load_data (snap_flat),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .overrun   (overrun)
    );

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
    parameter int         NUM       = 4,
    parameter int         CNT_W     = 32,
    parameter logic [7:0] SYNC_BYTE = 8'hA5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic [NUM*CNT_W-1:0] counts,
    input logic                 tx_valid,
    input logic                 tx_ready,
    input logic [7:0]           tx_data,
    input logic                 overrun
);

    // R5
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R4
    frame_starts_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_data == SYNC_BYTE));

    for (genvar g = 0; g < NUM; g++) begin : g_chk
        // R3
        restart_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> (counts[g*CNT_W +: CNT_W] <= CNT_W'(1)));

        // R6
        no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> (counts[g*CNT_W +: CNT_W] >= $past(counts[g*CNT_W +: CNT_W])));
    end

endmodule

bind bus_stats_collector bsc_checker #(
    .NUM       (bsc_pkg::NUM_CLASSES),
    .CNT_W     (CNT_W),
    .SYNC_BYTE (SYNC_BYTE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (win_tick),
    .counts   (cnt_flat),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .overrun  (overrun)
);

// File: tb/tb_bus_stats_collector.sv
module tb_bus_stats_collector;

    localparam int W_MAIN   = 64;
    localparam int W_SAT    = 1024;
    localparam int LAST_E   = 1070;
    localparam int NB_MAIN  = 4;
    localparam int NB_SAT   = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_valid = 1'b0;
    logic [1:0] txn_type = 2'd0;
    logic snoop_hit = 1'b0;
    logic tx_ready = 1'b0;
    logic tx_valid, tx_valid_sat, overrun, overrun_sat;
    logic [7:0] tx_data, tx_data_sat;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] q_main[$];
    logic [7:0] q_sat[$];
    longint unsigned exp_main[1:16][0:3];
    longint unsigned exp_sat[0:3];

    always #2 clk = ~clk;

    bus_stats_collector #(.WINDOW_CYCLES(W_MAIN), .CNT_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_type(txn_type),
        .snoop_hit(snoop_hit), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .overrun(overrun));

    bus_stats_collector #(.WINDOW_CYCLES(W_SAT), .CNT_W(8)) dut_sat (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_type(txn_type),
        .snoop_hit(snoop_hit), .tx_ready(1'b1), .tx_valid(tx_valid_sat),
        .tx_data(tx_data_sat), .overrun(overrun_sat));

    // byte monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) q_main.push_back(tx_data);
        if (rst_n && tx_valid_sat) q_sat.push_back(tx_data_sat);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic pattern(input int e, output bit v, output int t, output bit h);
        int win;
        win = (e - 1) / W_MAIN + 1;
        if (win == 5) begin
            // only ignored traffic: type 3, or hits without strobe
            if (e % 2 == 1) begin v = 1'b0; t = e % 4; h = 1'b1; end
            else begin v = 1'b1; t = 3; h = (e % 3 == 0); end
        end else if (win == 7 || win >= 9) begin
            v = 1'b1; t = 0; h = 1'b1;
        end else begin
            v = ((e + win) % 3) != 0;
            t = (e * 5 + win) % 4;
            h = ((e + 2 * win) % 5) < 2;
        end
    endtask

    function automatic longint unsigned sat_add(longint unsigned a, longint unsigned lim);
        return (a >= lim) ? lim : a + 1;
    endfunction

    task automatic account(input int e, input bit v, input int t, input bit h);
        bit [3:0] inc;
        int wm;
        inc = '0;
        if (v) begin
            inc[0] = h && (t == 0 || t == 2);
            inc[1] = (t == 1);
            inc[2] = (t == 2);
            inc[3] = (t == 0);
        end
        wm = (e - 1) / W_MAIN + 1;
        for (int c = 0; c < 4; c++) begin
            if (inc[c]) begin
                if (wm <= 16) exp_main[wm][c] = sat_add(exp_main[wm][c], 64'hFFFF_FFFF);
                if (e <= W_SAT) exp_sat[c] = sat_add(exp_sat[c], 255);
            end
        end
    endtask

    task automatic check_frames(input string tag);
        int p;
        int wins[15] = '{1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 12, 13, 14, 15, 16};
        p = 0;
        foreach (wins[i]) begin
            if (p + 1 + 4 * NB_MAIN > q_main.size()) begin
                check(1'b0, "R4", $sformatf("frame for window %0d missing, bytes", wins[i]),
                      q_main.size(), p + 17);
                return;
            end
            check(q_main[p] == 8'hA5, "R4", "sync byte", q_main[p], 8'hA5);
            p++;
            for (int c = 0; c < 4; c++) begin
                longint unsigned val;
                val = 0;
                for (int b = 0; b < NB_MAIN; b++) val |= longint'(q_main[p + b]) << (8 * b);
                p += NB_MAIN;
                check(val == exp_main[wins[i]][c],
                      (wins[i] == 5) ? "R1" : (c == 0 ? "R2" : (wins[i] == 6 ? "R7" : "R3")),
                      $sformatf("%s window %0d class %0d", tag, wins[i], c),
                      val, exp_main[wins[i]][c]);
            end
        end
        check(q_main.size() == p, "R9", "no extra bytes after last frame", q_main.size(), p);
    endtask

    initial begin
        for (int w = 1; w <= 16; w++) for (int c = 0; c < 4; c++) exp_main[w][c] = 0;
        for (int c = 0; c < 4; c++) exp_sat[c] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R8
        check(tx_valid == 1'b0, "R8", "tx_valid in reset", tx_valid, 0);
        check(overrun == 1'b0, "R8", "overrun in reset", overrun, 0);
        rst_n = 1'b1;
        for (int e = 1; e <= LAST_E; e++) begin
            bit v; int t; bit h; int win;
            pattern(e, v, t, h);
            win = (e - 1) / W_MAIN + 1;
            txn_valid = v; txn_type = 2'(t); snoop_hit = h;
            if (e >= 385 && e <= 460) tx_ready = 1'b0;
            else if (win % 2 == 0 && win < 9) tx_ready = (e % 4) != 0;
            else tx_ready = 1'b1;
            account(e, v, t, h);
            if (e == 64) check(tx_valid == 1'b0, "R9", "no frame before first window end", tx_valid, 0);
            if (e == 65) check(tx_valid && tx_data == 8'hA5, "R3", "frame offered after edge W", tx_data, 8'hA5);
            if (e == 60) check(tx_valid == 1'b0 && q_main.size() == 0, "R9", "idle before first window", q_main.size(), 0);
            if (e == 420) check(tx_valid && tx_data == 8'hA5, "R5", "sync byte held while stalled", tx_data, 8'hA5);
            if (e == 448) check(overrun == 1'b0, "R7", "overrun before second window end", overrun, 0);
            if (e == 449) check(overrun == 1'b1, "R7", "overrun after dropped snapshot", overrun, 1);
            if (e == 500) check(tx_valid == 1'b0, "R9", "tx_valid low after frame", tx_valid, 0);
            if (e == 1060) check(overrun == 1'b1, "R7", "overrun stays set", overrun, 1);
            if (e == 1060) check(overrun_sat == 1'b0, "R7", "no overrun without congestion", overrun_sat, 0);
            @(posedge clk);
            #1;
        end
        txn_valid = 1'b0;
        check_frames("main");
        // R6 saturation instance: one frame, 8-bit counters
        check(q_sat.size() == 5, "R6", "saturating frame length", q_sat.size(), 5);
        if (q_sat.size() == 5) begin
            check(q_sat[0] == 8'hA5, "R4", "sat sync byte", q_sat[0], 8'hA5);
            for (int c = 0; c < 4; c++)
                check(q_sat[1 + c] == 8'(exp_sat[c]), "R6",
                      $sformatf("saturating class %0d", c), q_sat[1 + c], exp_sat[c]);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule